// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This block sits between a synchronous host port and an asynchronous 16-bit DRAM that takes row and column addresses over one shared address bus. The host presents one request at a time: an address, a read/write flag, two byte enables and write data, under a valid/ready handshake. Read results come back with a one-cycle valid pulse. The controller generates the row strobe, two column strobes (one for each byte lane), the write strobe, the output-enable strobe, the shared address bus and the data driver enable. Every timing interval is a parameter counted in clock cycles.

After an access the row stays open. A later request to the same row then needs only a column cycle. A request to another row, a pending refresh, or an open time close to the longest allowed row-strobe low time closes the row first. A free-running interval counter requests a refresh in which the column strobes fall before the row strobe. Such a refresh needs no address and takes priority over host traffic. Writes are issued as early writes: the write strobe falls before the column strobes and the DRAM outputs stay off.

Top module: `fpm_ctrl`

## Requirements
- R1: While reset is held, all DRAM strobes (row, both column lanes, write, output enable) are high, the data driver enable is low and rd_valid is low.
- R2: A host address is split as {row, column}, with the row in the upper ROW_W bits. The row is on the bus before the row strobe falls and stays there for at least the first cycle it is low. The column is on the bus when a column strobe falls. Data written to an address is returned by a later read of that address.
- R3: Byte enable bit 0 drives the lower column strobe and covers data bits 7:0. Bit 1 drives the upper strobe and covers bits 15:8. A byte that is not enabled keeps its stored value on a write.
- R4: A request to the row that is already open is served without a new fall of the row strobe.
- R5: Between two falls of the row strobe it stays high for at least T_RP cycles, including after a row miss.
- R6: A refresh lowers both column strobes for at least T_CSR cycles before the row strobe falls, with write and output enable high. On average one refresh is issued every T_REFI cycles.
- R7: A pending refresh blocks new host requests and closes any open row. A continuous stream of same-row requests therefore cannot delay refreshes.
- R8: On a write, the write strobe is already low in the cycle before the column strobes fall. Write data is driven at that fall. The data drivers are enabled only while output enable is high.
- R9: For a read, the column strobes stay low for exactly T_CAS cycles. Data is captured on the edge that raises them, and rd_valid is high for exactly one cycle, in the cycle the strobes are high again.
- R10: The row strobe is never low for more than T_RAS_MAX cycles. An idle open row is closed without any host action.
- R11: Each low period of the row strobe lasts at least T_RAS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | ROW_W+COL_W | Word address {row, column} |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0 |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Lower-lane column strobe, active low |
| dram_cash_n | output | 1 | Upper-lane column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address |
| dram_dq_out | output | 16 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
The controller drives a cycle-sampled DRAM model, and its strobe sequence is exercised by several request patterns. Bursts to one row separate page hits from needless reopening. Alternating rows exercise the close and precharge path. Mixed byte-lane writes followed by word reads show whether an unselected lane was disturbed. Long idle gaps force the row to close on the low-time limit and let refreshes fall between accesses. A long unbroken stream of same-row requests shows whether refresh keeps its priority. A final read of every word compares the whole model array with the expected contents.

// File: rtl/fpm_ctrl.sv
module fpm_ctrl #(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 10,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_RAS     = 5,
  parameter int T_RAS_MAX = 1000,
  parameter int T_CSR     = 1,
  parameter int T_REFI    = 1560
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     req_valid,
  output logic                                     req_ready,
  input  logic [ROW_W+COL_W-1:0]                   req_addr,
  input  logic                                     req_we,
  input  logic [1:0]                               req_be,
  input  logic [15:0]                              req_wdata,
  output logic                                     rd_valid,
  output logic [15:0]                              rd_data,
  output logic                                     dram_ras_n,
  output logic                                     dram_casl_n,
  output logic                                     dram_cash_n,
  output logic                                     dram_we_n,
  output logic                                     dram_oe_n,
  output logic [(ROW_W > COL_W ? ROW_W : COL_W)-1:0] dram_addr,
  output logic [15:0]                              dram_dq_out,
  output logic                                     dram_dq_oe,
  input  logic [15:0]                              dram_dq_in
);
  localparam int AW  = ROW_W + COL_W;
  localparam int MW  = ROW_W > COL_W ? ROW_W : COL_W;
  localparam int CW  = $clog2(T_RP + T_RCD + T_CAS + T_CP + T_RAS + T_CSR + 1);
  localparam int AGW = $clog2(T_RAS_MAX + T_RAS + 2);
  localparam int RFW = $clog2(T_REFI + 1);
  localparam logic [AGW-1:0] HIT_LIM  = AGW'(T_RAS_MAX - 3 - T_CAS - T_CP);
  localparam logic [AGW-1:0] MIN_AGE  = AGW'(T_RAS - 1);
  localparam logic [RFW-1:0] REFI_END = RFW'(T_REFI - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ROW, S_RAH, S_COL, S_CAS, S_CP, S_OPEN, S_PRE, S_REFC, S_REFR
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [AGW-1:0]   age;
  logic [RFW-1:0]   rcnt;
  logic             ref_pend;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             we_q;
  logic [1:0]       be_q;
  logic [15:0]      wd_q;

  wire [ROW_W-1:0] req_row = req_addr[AW-1:COL_W];
  wire             hit     = req_row == row_q;
  wire             last    = cnt == '0;
  wire             take    = req_valid && req_ready;
  wire             close   = (st == S_OPEN) && age >= MIN_AGE &&
                             (ref_pend || (req_valid && !hit) || age > HIT_LIM);

  assign req_ready = !ref_pend &&
                     ((st == S_IDLE) || (st == S_OPEN && hit && age <= HIT_LIM));

  wire ref_cas = st inside {S_REFC, S_REFR};
  wire acc_cas = st == S_CAS;
  wire wr_phase = we_q && (st inside {S_COL, S_CAS});

  assign dram_ras_n  = !(st inside {S_RAH, S_COL, S_CAS, S_CP, S_OPEN, S_REFR});
  assign dram_casl_n = !(ref_cas || (acc_cas && be_q[0]));
  assign dram_cash_n = !(ref_cas || (acc_cas && be_q[1]));
  assign dram_we_n   = !wr_phase;
  assign dram_oe_n   = !(!we_q && acc_cas);
  assign dram_dq_oe  = wr_phase;
  assign dram_dq_out = wd_q;
  assign dram_addr   = (st inside {S_ROW, S_RAH}) ? MW'(row_q) : MW'(col_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      age      <= '0;
      rcnt     <= '0;
      ref_pend <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      we_q     <= 1'b0;
      be_q     <= '0;
      wd_q     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      cnt      <= cnt - 1'b1;
      age      <= dram_ras_n ? '0 : age + 1'b1;
      if (take) begin
        col_q <= req_addr[COL_W-1:0];
        we_q  <= req_we;
        be_q  <= req_be;
        wd_q  <= req_wdata;
      end
      case (st)
        S_IDLE:
          if (ref_pend) begin
            st       <= S_REFC;
            cnt      <= CW'(T_CSR - 1);
            ref_pend <= 1'b0;
          end else if (take) begin
            st    <= S_ROW;
            row_q <= req_row;
          end
        S_ROW: begin
          st  <= S_RAH;
          cnt <= CW'(T_RCD - 2);
        end
        S_RAH:  if (last) st <= S_COL;
        S_COL: begin
          st  <= S_CAS;
          cnt <= CW'(T_CAS - 1);
        end
        S_CAS:
          if (last) begin
            st  <= S_CP;
            cnt <= CW'(T_CP - 1);
            if (!we_q) begin
              rd_valid <= 1'b1;
              rd_data  <= dram_dq_in;
            end
          end
        S_CP:   if (last) st <= S_OPEN;
        S_OPEN:
          if (take) st <= S_COL;
          else if (close) begin
            st  <= S_PRE;
            cnt <= CW'(T_RP - 1);
          end
        S_PRE:  if (last) st <= S_IDLE;
        S_REFC:
          if (last) begin
            st  <= S_REFR;
            cnt <= CW'(T_RAS - 1);
          end
        S_REFR:
          if (last) begin
            st  <= S_PRE;
            cnt <= CW'(T_RP - 1);
          end
        default: st <= S_IDLE;
      endcase
      if (rcnt == REFI_END) begin
        rcnt     <= '0;
        ref_pend <= 1'b1;
      end else begin
        rcnt <= rcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpm_ctrl_chk.sv
module fpm_ctrl_chk #(
  parameter int MW        = 12,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 5,
  parameter int T_RAS_MAX = 1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          casl_n,
  input logic          cash_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic          rd_valid,
  input logic [MW-1:0] addr
);
  int unsigned hi_run, lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= T_RP;
      lo_run <= 0;
    end else begin
      hi_run <= ras_n ? hi_run + 1 : 0;
      lo_run <= ras_n ? 0 : lo_run + 1;
    end
  end

  AST_DRIVE_ONLY_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n); // R8
  AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !we_n && ($fell(casl_n) || $fell(cash_n))) |-> $past(!we_n)); // R8
  AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R9
  AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!casl_n && ras_n) |-> (!cash_n && we_n && oe_n)); // R6
  AST_ROW_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && casl_n && cash_n) |-> $stable(addr)); // R2
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_run >= T_RP); // R5
  AST_RAS_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> lo_run >= T_RAS); // R11
  AST_RAS_LOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> lo_run < T_RAS_MAX); // R10
endmodule

bind fpm_ctrl fpm_ctrl_chk #(
  .MW(ROW_W > COL_W ? ROW_W : COL_W),
  .T_RP(T_RP),
  .T_RAS(T_RAS),
  .T_RAS_MAX(T_RAS_MAX)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .ras_n(dram_ras_n),
  .casl_n(dram_casl_n),
  .cash_n(dram_cash_n),
  .we_n(dram_we_n),
  .oe_n(dram_oe_n),
  .dq_oe(dram_dq_oe),
  .rd_valid(rd_valid),
  .addr(dram_addr)
);

// File: tb/fpm_ctrl_tb.sv
`timescale 1ns/1ps
module fpm_ctrl_tb;
  localparam int RW = 4, CLW = 4, AW = 8;
  localparam int TRP = 6, TRCD = 4, TCAS = 3, TCP = 2, TRAS = 10;
  localparam int TRASMAX = 60, TCSR = 2, TREFI = 200;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, req_valid, req_ready, req_we, rd_valid;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_be;
  logic [15:0]   req_wdata, rd_data, dram_dq_out, dram_dq_in;
  logic          dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [3:0]    dram_addr;

  fpm_ctrl #(.ROW_W(RW), .COL_W(CLW), .T_RP(TRP), .T_RCD(TRCD), .T_CAS(TCAS),
             .T_CP(TCP), .T_RAS(TRAS), .T_RAS_MAX(TRASMAX), .T_CSR(TCSR),
             .T_REFI(TREFI)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(dram_ras_n),
    .dram_casl_n(dram_casl_n), .dram_cash_n(dram_cash_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  logic [15:0] dmem [256];
  logic [15:0] rmem [256];
  logic [3:0]  m_row, m_col;
  assign dram_dq_in = dmem[{m_row, m_col}];

  int total = 0, bad = 0;
  int ras_falls = 0, ras_rises = 0, cbr_cnt = 0, cyc = 0, max_low = 0;
  int ras_lo, ras_hi, cas_lo;
  logic p_ras, p_casl, p_cash, p_we;
  bit last_wr;
  logic [17:0] exp_q [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                         input logic [1:0] be);
    return {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  always @(posedge clk) if (rst_n) cyc++;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 1; p_casl = 1; p_cash = 1; p_we = 1;
      ras_lo = 0; ras_hi = 100; cas_lo = 0; last_wr = 0;
    end else begin
      if (p_ras && !dram_ras_n) begin
        ras_falls++;
        if (!dram_casl_n && !dram_cash_n) begin
          cbr_cnt++;
          chk(cas_lo >= TCSR && dram_we_n && dram_oe_n, "R6 refresh setup", cas_lo, TCSR);
        end else begin
          chk(ras_hi >= TRP, "R5 precharge", ras_hi, TRP);
          m_row = dram_addr;
        end
      end
      if (!p_ras && dram_ras_n) begin
        ras_rises++;
        chk(ras_lo >= TRAS, "R11 ras low min", ras_lo, TRAS);
        chk(ras_lo <= TRASMAX, "R10 ras low max", ras_lo, TRASMAX);
        if (ras_lo > max_low) max_low = ras_lo;
      end
      if (!p_ras && !dram_ras_n && p_casl && p_cash && !(dram_casl_n && dram_cash_n)) begin
        m_col   = dram_addr;
        last_wr = !dram_we_n;
        if (!dram_we_n) begin
          chk(!p_we && dram_oe_n && dram_dq_oe, "R8 early write", {p_we, dram_oe_n, dram_dq_oe}, 3'b011);
          if (!dram_casl_n) dmem[{m_row, m_col}][7:0]  = dram_dq_out[7:0];
          if (!dram_cash_n) dmem[{m_row, m_col}][15:8] = dram_dq_out[15:8];
        end
      end
      if (!dram_ras_n && !(p_casl && p_cash) && dram_casl_n && dram_cash_n && !last_wr)
        chk(rd_valid && cas_lo == TCAS, "R9 capture timing", {rd_valid, 8'(cas_lo)}, {1'b1, 8'(TCAS)});
      if (dram_dq_oe) chk(dram_oe_n, "R8 drivers vs oe", dram_oe_n, 1);
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected rd_valid", 1, 0);
        else begin
          logic [17:0] e;
          e = exp_q.pop_front();
          chk((rd_data & lane_mask(e[17:16])) == (e[15:0] & lane_mask(e[17:16])),
              "R2/R3 read data", rd_data & lane_mask(e[17:16]), e[15:0] & lane_mask(e[17:16]));
        end
      end
      ras_lo = dram_ras_n ? 0 : ras_lo + 1;
      ras_hi = dram_ras_n ? ras_hi + 1 : 0;
      cas_lo = (dram_casl_n && dram_cash_n) ? 0 : cas_lo + 1;
      p_ras = dram_ras_n; p_casl = dram_casl_n; p_cash = dram_cash_n; p_we = dram_we_n;
    end
  end

  task automatic req(input logic [AW-1:0] a, input bit w, input logic [1:0] b,
                     input logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_we = w; req_be = b; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (w) rmem[a] = merge(rmem[a], d, b);
    else exp_q.push_back({b, rmem[a]});
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f0, c0, r0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      dmem[i] = 16'(i * 16'h0101) ^ 16'h5a3c;
      rmem[i] = dmem[i];
    end
    rst_n = 0; req_valid = 0; req_addr = '0; req_we = 0; req_be = 0; req_wdata = 0;
    m_row = 0; m_col = 0;
    repeat (3) @(negedge clk);
    chk({dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n} == 5'b11111,
        "R1 strobes in reset", {dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n}, 5'b11111);
    chk(!dram_dq_oe && !rd_valid, "R1 drivers/valid in reset", {dram_dq_oe, rd_valid}, 0);
    rst_n = 1;

    f0 = ras_falls;
    req({4'd1, 4'd2}, 1, 2'b11, 16'hbeef);
    req({4'd1, 4'd5}, 0, 2'b11, 0);
    req({4'd1, 4'd2}, 0, 2'b11, 0);
    repeat (10) @(negedge clk);
    chk(ras_falls - f0 == 1, "R4 page hit keeps row", ras_falls - f0, 1);

    req({4'd2, 4'd3}, 1, 2'b11, 16'ha5a5);
    req({4'd2, 4'd3}, 1, 2'b01, 16'h1234);
    req({4'd2, 4'd3}, 1, 2'b10, 16'h5600);
    req({4'd2, 4'd3}, 0, 2'b11, 0);
    req({4'd2, 4'd3}, 0, 2'b10, 0);
    req({4'd2, 4'd4}, 1, 2'b10, 16'h77ff);
    req({4'd2, 4'd4}, 0, 2'b01, 0);

    f0 = ras_rises;
    req({4'd3, 4'd0}, 0, 2'b11, 0);
    req({4'd4, 4'd0}, 0, 2'b11, 0);
    repeat (5) @(negedge clk);
    chk(ras_rises - f0 >= 2, "R5 row miss closes row", ras_rises - f0, 2);

    req({4'd6, 4'd1}, 0, 2'b11, 0);
    f0 = ras_rises;
    repeat (80) @(negedge clk);
    chk(ras_rises > f0, "R10 idle row closed", ras_rises - f0, 1);

    c0 = cyc; r0 = cbr_cnt;
    for (int i = 0; i < 150; i++)
      req({4'd5, 4'(i)}, i[0], 2'b11, 16'(i * 16'h0f1d));
    chk(cbr_cnt - r0 >= (cyc - c0) / TREFI - 1, "R7 refresh beats hit stream",
        cbr_cnt - r0, (cyc - c0) / TREFI - 1);

    for (int i = 0; i < 300; i++) begin
      int g;
      logic [AW-1:0] a;
      a = {4'($urandom % 4), 4'($urandom % 16)};
      req(a, 1'($urandom % 2), 2'(1 + $urandom % 3), 16'($urandom));
      g = $urandom % 16;
      if (g == 0) repeat (70) @(negedge clk);
      else if (g < 6) repeat (g) @(negedge clk);
    end

    for (int i = 0; i < 256; i++) req(8'(i), 0, 2'b11, 0);
    repeat (40) @(negedge clk);

    chk(exp_q.size() == 0, "R9 every read returned", exp_q.size(), 0);
    chk(cbr_cnt >= cyc / TREFI - 1 && cbr_cnt <= cyc / TREFI, "R6 refresh count",
        cbr_cnt, cyc / TREFI);
    chk(max_low <= TRASMAX, "R10 longest ras low", max_low, TRASMAX);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule